// File: doc/BRIEF.md
# Ternary CAM Search Engine

This block is a small ternary content-addressable table. Each entry holds a 68-bit value, a 68-bit local don't-care mask and a valid bit. A search is a two-cycle command on a 68-bit key bus. The first cycle selects a pair of global mask registers. The second cycle selects a pair of comparand registers, and the key is stored into that pair. The key is compared in parallel against every valid entry. The lowest-numbered matching entry wins, and its index is driven as an external SRAM address with active-low chip-enable and address-latch strobes.

The pipeline accepts a new command every two clock cycles. Results leave in command order at a fixed latency. A search-valid flag and a search-found flag follow the SRAM strobes after a configurable number of extra cycles. A miss raises search-valid alone, and the SRAM address keeps its last value. Entries and global mask pairs are loaded through single-cycle write ports. The comparand file has a read port.

Top module: `tcam_search_engine`

## Requirements
- R1: While reset is held, and directly after it, sram_ce_n, sram_ale_n and sram_we_n are 1, srch_valid and srch_found are 0, and sram_addr is 0. Every global mask register resets to all ones.
- R2: A command starts when cmd_valid is 1 in an idle cycle (cycle A). The next cycle is always its cycle B, whatever the value of cmd_valid. In cycle A, cmd_idx is the global mask pair index. In cycle B, cmd_idx is the comparand pair index and key_bus carries the search key.
- R3: An entry matches only if its valid bit is 1 and, for each bit, the global mask bit is 0, or the entry's local mask bit is 1, or the key bit equals the entry bit.
- R4: The effective global mask is the AND of registers 2p and 2p+1 for pair index p. A write through gm_we loads gm_wdata into both registers of pair gm_wsel in one cycle.
- R5: In cycle B, the key is written into comparand registers 2p and 2p+1 for pair p. Register s reads back on cmp_rd_data when cmp_rd_sel = s.
- R6: When several entries match, the lowest index wins.
- R7: On a hit, the clock edge that is 4 edges after the edge that samples cycle A loads sram_addr with the winning index, zero-extended. The same edge drives sram_ce_n and sram_ale_n low for exactly one cycle. sram_we_n stays 1 at all times.
- R8: srch_valid is 1 for one cycle, HIT_LAT edges after the edge that loads the strobes. srch_found is 1 in that same cycle if the search hit, and is never 1 without srch_valid.
- R9: On a miss, srch_valid is raised with srch_found at 0. sram_ce_n and sram_ale_n stay 1, and sram_addr holds its previous value.
- R10: Commands may be issued every two cycles. Each result keeps its own latency, so results leave in command order.
- R11: ent_we writes ent_wdata, ent_wlmask and ent_wvalid into entry ent_waddr in one cycle. Writing ent_wvalid = 0 stops the entry from matching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Starts a search command (cycle A) |
| cmd_idx | input | 2 | Mask pair index in cycle A, comparand pair index in cycle B |
| key_bus | input | 68 | Search key |
| ent_we | input | 1 | Entry write enable |
| ent_waddr | input | 5 | Entry write index |
| ent_wvalid | input | 1 | Valid bit written to the entry |
| ent_wdata | input | 68 | Entry value |
| ent_wlmask | input | 68 | Entry local don't-care mask (1 = ignore bit) |
| gm_we | input | 1 | Global mask pair write enable |
| gm_wsel | input | 2 | Global mask pair index to write |
| gm_wdata | input | 68 | Global mask value (1 = compare bit) |
| cmp_rd_sel | input | 3 | Comparand register read select |
| cmp_rd_data | output | 68 | Selected comparand register |
| sram_addr | output | 22 | Winning index as SRAM address |
| sram_ce_n | output | 1 | SRAM chip enable, active low |
| sram_ale_n | output | 1 | SRAM address latch enable, active low |
| sram_we_n | output | 1 | SRAM write enable, active low, held high |
| srch_valid | output | 1 | Search result valid |
| srch_found | output | 1 | Search result was a hit |

## Verification
The table is loaded with entries that tell the match rules apart.
- A key that two entries match shows that the lowest index wins.
- A key that differs from an entry only in bits that entry's local mask covers shows the local don't-care bits working.
- One key is searched under two mask pairs, and only one of them clears the differing top bit. The result depends on which pair is chosen.
- One entry is written and then cleared, which shows the valid bit being honoured.
- Hits on entries 0 and 31 cover both ends of the table.

Three back-to-back commands (hit, miss, hit) show the results leaving in order and the address holding across the miss. A command that keeps cmd_valid high through its cycle B must produce exactly one result. The comparand read port shows the key stored in both registers of the chosen pair.

// File: rtl/tcam_pkg.sv
`timescale 1ns/1ps
package tcam_pkg;
    localparam int KEY_W_DEF = 68;
    localparam int ADDR_W_DEF = 22;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_SECOND = 1'b1
    } cmd_phase_e;
endpackage

// File: rtl/tcam_entry_array.sv
`timescale 1ns/1ps
module tcam_entry_array #(
    parameter int KEY_W = 68,
    parameter int DEPTH = 32,
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_addr,
    input  logic             wr_valid,
    input  logic [KEY_W-1:0] wr_data,
    input  logic [KEY_W-1:0] wr_lmask,
    input  logic [KEY_W-1:0] srch_key,
    input  logic [KEY_W-1:0] srch_mask,
    output logic [DEPTH-1:0] hit_vec
);
    logic [DEPTH-1:0] valid_q;

    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        logic [KEY_W-1:0] data_q;
        logic [KEY_W-1:0] lmask_q;
        logic             sel;

        assign sel = wr_en && (wr_addr == IDX_W'(i));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                valid_q[i] <= 1'b0;
            end else if (sel) begin
                valid_q[i] <= wr_valid;
            end
        end

        always_ff @(posedge clk) begin
            if (sel) begin
                data_q  <= wr_data;
                lmask_q <= wr_lmask;
            end
        end

        // A bit takes part in the compare only if the global mask selects it
        // and the entry does not mark it as don't-care.
        assign hit_vec[i] = valid_q[i] &&
                            (((srch_key ^ data_q) & srch_mask & ~lmask_q) == '0);
    end
endmodule

// File: rtl/tcam_prio_enc.sv
`timescale 1ns/1ps
module tcam_prio_enc #(
    parameter int DEPTH = 32,
    parameter int IDX_W = 5
) (
    input  logic [DEPTH-1:0] req,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        any = |req;
        idx = '0;
        // Walk downward so the lowest set position is the one left standing.
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (req[i]) begin
                idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/tcam_flag_delay.sv
`timescale 1ns/1ps
module tcam_flag_delay #(
    parameter int STAGES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_vld,
    input  logic in_hit,
    output logic out_vld,
    output logic out_hit
);
    typedef struct packed {
        logic [STAGES-1:0] vld;
        logic [STAGES-1:0] hit;
    } dly_t;

    dly_t dly_d, dly_q;

    always_comb begin
        dly_d = dly_q;
        dly_d.vld[0] = in_vld;
        dly_d.hit[0] = in_vld && in_hit;
        for (int i = 1; i < STAGES; i++) begin
            dly_d.vld[i] = dly_q.vld[i-1];
            dly_d.hit[i] = dly_q.hit[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dly_q <= '0;
        end else begin
            dly_q <= dly_d;
        end
    end

    assign out_vld = dly_q.vld[STAGES-1];
    assign out_hit = dly_q.hit[STAGES-1];
endmodule

// File: rtl/tcam_search_engine.sv
`timescale 1ns/1ps
module tcam_search_engine #(
    parameter int KEY_W     = tcam_pkg::KEY_W_DEF,
    parameter int DEPTH     = 32,
    parameter int REG_PAIRS = 4,
    parameter int ADDR_W    = tcam_pkg::ADDR_W_DEF,
    parameter int HIT_LAT   = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cmd_valid,
    input  logic [$clog2(REG_PAIRS)-1:0]  cmd_idx,
    input  logic [KEY_W-1:0]              key_bus,
    input  logic                          ent_we,
    input  logic [$clog2(DEPTH)-1:0]      ent_waddr,
    input  logic                          ent_wvalid,
    input  logic [KEY_W-1:0]              ent_wdata,
    input  logic [KEY_W-1:0]              ent_wlmask,
    input  logic                          gm_we,
    input  logic [$clog2(REG_PAIRS)-1:0]  gm_wsel,
    input  logic [KEY_W-1:0]              gm_wdata,
    input  logic [$clog2(REG_PAIRS):0]    cmp_rd_sel,
    output logic [KEY_W-1:0]              cmp_rd_data,
    output logic [ADDR_W-1:0]             sram_addr,
    output logic                          sram_ce_n,
    output logic                          sram_ale_n,
    output logic                          sram_we_n,
    output logic                          srch_valid,
    output logic                          srch_found
);
    localparam int IDX_W  = $clog2(DEPTH);
    localparam int PAIR_W = $clog2(REG_PAIRS);
    localparam int NREG   = 2 * REG_PAIRS;

    typedef struct packed {
        tcam_pkg::cmd_phase_e             phase;
        logic [PAIR_W-1:0]                gm_sel;
        logic [NREG-1:0][KEY_W-1:0]       gmr;
        logic [NREG-1:0][KEY_W-1:0]       cmpr;
        logic                             s1_vld;
        logic [KEY_W-1:0]                 s1_key;
        logic [KEY_W-1:0]                 s1_msk;
        logic                             s2_vld;
        logic [DEPTH-1:0]                 s2_hits;
        logic                             s3_vld;
        logic                             s3_hit;
        logic [IDX_W-1:0]                 s3_idx;
        logic [ADDR_W-1:0]                addr;
        logic                             ce_n;
        logic                             ale_n;
    } eng_t;

    eng_t             st_d, st_q;
    logic [DEPTH-1:0] match_vec;
    logic             enc_any;
    logic [IDX_W-1:0] enc_idx;

    tcam_entry_array #(
        .KEY_W (KEY_W),
        .DEPTH (DEPTH),
        .IDX_W (IDX_W)
    ) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (ent_we),
        .wr_addr   (ent_waddr),
        .wr_valid  (ent_wvalid),
        .wr_data   (ent_wdata),
        .wr_lmask  (ent_wlmask),
        .srch_key  (st_q.s1_key),
        .srch_mask (st_q.s1_msk),
        .hit_vec   (match_vec)
    );

    tcam_prio_enc #(
        .DEPTH (DEPTH),
        .IDX_W (IDX_W)
    ) u_enc (
        .req (st_q.s2_hits),
        .any (enc_any),
        .idx (enc_idx)
    );

    tcam_flag_delay #(
        .STAGES (HIT_LAT + 1)
    ) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_vld  (st_q.s3_vld),
        .in_hit  (st_q.s3_hit),
        .out_vld (srch_valid),
        .out_hit (srch_found)
    );

    always_comb begin
        st_d = st_q;

        // Command front end: cycle A latches the mask pair, cycle B launches.
        st_d.s1_vld = 1'b0;
        if (st_q.phase == tcam_pkg::PH_SECOND) begin
            st_d.phase                 = tcam_pkg::PH_IDLE;
            st_d.cmpr[{cmd_idx, 1'b0}] = key_bus;
            st_d.cmpr[{cmd_idx, 1'b1}] = key_bus;
            st_d.s1_vld                = 1'b1;
            st_d.s1_key                = key_bus;
            st_d.s1_msk                = st_q.gmr[{st_q.gm_sel, 1'b0}] &
                                         st_q.gmr[{st_q.gm_sel, 1'b1}];
        end else if (cmd_valid) begin
            st_d.phase  = tcam_pkg::PH_SECOND;
            st_d.gm_sel = cmd_idx;
        end

        if (gm_we) begin
            st_d.gmr[{gm_wsel, 1'b0}] = gm_wdata;
            st_d.gmr[{gm_wsel, 1'b1}] = gm_wdata;
        end

        // Compare result, then priority result.
        st_d.s2_vld  = st_q.s1_vld;
        st_d.s2_hits = match_vec;
        st_d.s3_vld  = st_q.s2_vld;
        st_d.s3_hit  = enc_any;
        st_d.s3_idx  = enc_idx;

        // SRAM access: strobes only on a hit, address kept on a miss.
        st_d.ce_n  = 1'b1;
        st_d.ale_n = 1'b1;
        if (st_q.s3_vld && st_q.s3_hit) begin
            st_d.addr              = '0;
            st_d.addr[IDX_W-1:0]   = st_q.s3_idx;
            st_d.ce_n              = 1'b0;
            st_d.ale_n             = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.phase <= tcam_pkg::PH_IDLE;
            st_q.gmr   <= '1;
            st_q.ce_n  <= 1'b1;
            st_q.ale_n <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign cmp_rd_data = st_q.cmpr[cmp_rd_sel];
    assign sram_addr   = st_q.addr;
    assign sram_ce_n   = st_q.ce_n;
    assign sram_ale_n  = st_q.ale_n;
    assign sram_we_n   = 1'b1;
endmodule

// File: rtl/tcam_search_engine_chk.sv
`timescale 1ns/1ps
module tcam_search_engine_chk #(
    parameter int ADDR_W = 22
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] sram_addr,
    input logic              sram_ce_n,
    input logic              sram_ale_n,
    input logic              srch_valid,
    input logic              srch_found
);
    logic seen_edge_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_edge_q <= 1'b0;
        end else begin
            seen_edge_q <= 1'b1;
        end
    end

    assert_found_has_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        srch_found |-> srch_valid);

    assert_ce_single_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_ce_n |=> sram_ce_n);

    assert_ale_with_ce_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sram_ale_n == sram_ce_n);

    assert_valid_single_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        srch_valid |=> !srch_valid);

    assert_addr_moves_on_hit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_edge_q && (sram_addr != $past(sram_addr))) |-> !sram_ce_n);
endmodule

bind tcam_search_engine tcam_search_engine_chk #(
    .ADDR_W (ADDR_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .sram_addr  (sram_addr),
    .sram_ce_n  (sram_ce_n),
    .sram_ale_n (sram_ale_n),
    .srch_valid (srch_valid),
    .srch_found (srch_found)
);

// File: tb/tcam_search_engine_tb_top.sv
`timescale 1ns/1ps
module tcam_search_engine_tb_top;
    localparam int KW      = 68;
    localparam int AW      = 22;
    localparam int HIT_LAT = 2;
    localparam int NVEC    = 8;

    localparam logic [KW-1:0] K1 = 68'h12345_6789_ABCD_EF01;
    localparam logic [KW-1:0] K2 = 68'hF_0F0F_0F0F_0F0F_0F0F;
    localparam logic [KW-1:0] K3 = 68'h0_1111_2222_3333_4444;
    localparam logic [KW-1:0] K4 = 68'hA_AAAA_5555_AAAA_5555;
    localparam logic [KW-1:0] K5 = 68'h5_5555_0000_FFFF_1234;
    localparam logic [KW-1:0] K6 = 68'h3_0303_0303_0303_0303;

    // Vector table: key, mask pair, comparand pair, expected hit, expected index, requirement.
    localparam logic [KW-1:0] V_KEY [NVEC] = '{K1, K1 ^ 68'hF, K2, K3, K3, K4, K5, K6};
    localparam logic [1:0]    V_GM  [NVEC] = '{2'd0, 2'd0, 2'd0, 2'd0, 2'd1, 2'd0, 2'd0, 2'd0};
    localparam logic [1:0]    V_CMP [NVEC] = '{2'd0, 2'd1, 2'd2, 2'd3, 2'd0, 2'd1, 2'd2, 2'd3};
    localparam logic          V_HIT [NVEC] = '{1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1};
    localparam int            V_IDX [NVEC] = '{2, 5, 9, 0, 12, 0, 31, 0};
    localparam string         V_REQ [NVEC] = '{"R6", "R3", "R7", "R9", "R4", "R11", "R7", "R7"};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [1:0]    cmd_idx = '0;
    logic [KW-1:0] key_bus = '0;
    logic          ent_we = 1'b0;
    logic [4:0]    ent_waddr = '0;
    logic          ent_wvalid = 1'b0;
    logic [KW-1:0] ent_wdata = '0;
    logic [KW-1:0] ent_wlmask = '0;
    logic          gm_we = 1'b0;
    logic [1:0]    gm_wsel = '0;
    logic [KW-1:0] gm_wdata = '0;
    logic [2:0]    cmp_rd_sel = '0;
    logic [KW-1:0] cmp_rd_data;
    logic [AW-1:0] sram_addr;
    logic          sram_ce_n, sram_ale_n, sram_we_n, srch_valid, srch_found;

    int checks = 0;
    int fails  = 0;
    logic [AW-1:0] last_addr = '0;

    always #2.5 clk = ~clk;

    tcam_search_engine #(.HIT_LAT(HIT_LAT)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_idx(cmd_idx),
        .key_bus(key_bus), .ent_we(ent_we), .ent_waddr(ent_waddr),
        .ent_wvalid(ent_wvalid), .ent_wdata(ent_wdata), .ent_wlmask(ent_wlmask),
        .gm_we(gm_we), .gm_wsel(gm_wsel), .gm_wdata(gm_wdata),
        .cmp_rd_sel(cmp_rd_sel), .cmp_rd_data(cmp_rd_data),
        .sram_addr(sram_addr), .sram_ce_n(sram_ce_n), .sram_ale_n(sram_ale_n),
        .sram_we_n(sram_we_n), .srch_valid(srch_valid), .srch_found(srch_found)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [KW-1:0] act, input logic [KW-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wr_entry(input int a, input logic v, input logic [KW-1:0] d,
                            input logic [KW-1:0] m);
        ent_we = 1'b1; ent_waddr = 5'(a); ent_wvalid = v; ent_wdata = d; ent_wlmask = m;
        @(negedge clk);
        ent_we = 1'b0;
    endtask

    task automatic wr_gm(input logic [1:0] p, input logic [KW-1:0] d);
        gm_we = 1'b1; gm_wsel = p; gm_wdata = d;
        @(negedge clk);
        gm_we = 1'b0;
    endtask

    // Command at negedge 0; strobes sampled at negedge 5, flags at 5+HIT_LAT.
    task automatic run_search(input logic [KW-1:0] key, input logic [1:0] gm,
                              input logic [1:0] cp, input logic hit, input int idx,
                              input string req);
        logic [AW-1:0] exp_addr;
        exp_addr = hit ? AW'(idx) : last_addr;
        cmd_valid = 1'b1; cmd_idx = gm; key_bus = key;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_idx = cp;
        @(negedge clk);
        cmd_idx = '0; key_bus = '0;
        repeat (2) @(negedge clk);
        chk(sram_ce_n == 1'b1, "R7", "ce_n early", KW'(sram_ce_n), KW'(1));
        @(negedge clk);
        chk(sram_ce_n == !hit && sram_ale_n == !hit, req, "ce_n/ale_n",
            KW'({sram_ce_n, sram_ale_n}), KW'({!hit, !hit}));
        chk(sram_addr == exp_addr, req, "sram_addr", KW'(sram_addr), KW'(exp_addr));
        chk(srch_valid == 1'b0, "R8", "valid early", KW'(srch_valid), KW'(0));
        repeat (HIT_LAT) @(negedge clk);
        chk(srch_valid == 1'b1 && srch_found == hit, req, "valid/found",
            KW'({srch_valid, srch_found}), KW'({1'b1, hit}));
        @(negedge clk);
        chk(srch_valid == 1'b0, "R8", "valid one cycle", KW'(srch_valid), KW'(0));
        last_addr = exp_addr;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(sram_ce_n && sram_ale_n && sram_we_n, "R1", "strobes in reset",
            KW'({sram_ce_n, sram_ale_n, sram_we_n}), KW'(3'b111));
        chk(!srch_valid && !srch_found, "R1", "flags in reset",
            KW'({srch_valid, srch_found}), KW'(0));
        chk(sram_addr == '0, "R1", "addr in reset", KW'(sram_addr), KW'(0));
        rst_n = 1'b1;
        @(negedge clk);
        chk(sram_ce_n && sram_ale_n && !srch_valid, "R1", "after reset",
            KW'({sram_ce_n, sram_ale_n, srch_valid}), KW'(3'b110));

        // R11 table load, R4 mask pair 1 ignores the top bit
        wr_entry(2, 1'b1, K1, '0);
        wr_entry(5, 1'b1, K1 ^ 68'hF, 68'hF);
        wr_entry(9, 1'b1, K2, '0);
        wr_entry(12, 1'b1, K3 ^ (68'h1 << 67), '0);
        wr_entry(20, 1'b1, K4, '0);
        wr_entry(20, 1'b0, K4, '0);
        wr_entry(31, 1'b1, K5, '0);
        wr_entry(0, 1'b1, K6, '0);
        wr_gm(2'd1, ~(68'h1 << 67));

        for (int v = 0; v < NVEC; v++) begin
            run_search(V_KEY[v], V_GM[v], V_CMP[v], V_HIT[v], V_IDX[v], V_REQ[v]);
        end

        // R1 mask pair 0 still all ones: K3 under pair 0 misses (checked above);
        // R5 comparand pair 3 holds the last key sent with it (K6)
        cmp_rd_sel = 3'd6;
        #1;
        chk(cmp_rd_data == K6, "R5", "cmp reg 6", cmp_rd_data, K6);
        cmp_rd_sel = 3'd7;
        #1;
        chk(cmp_rd_data == K6, "R5", "cmp reg 7", cmp_rd_data, K6);
        cmp_rd_sel = 3'd2;
        #1;
        chk(cmp_rd_data == K4, "R5", "cmp reg 2", cmp_rd_data, K4);
        @(negedge clk);

        // R2 cmd_valid held through cycle B gives exactly one result
        begin
            int pulses;
            pulses = 0;
            cmd_valid = 1'b1; cmd_idx = 2'd0; key_bus = K2;
            @(negedge clk);
            cmd_idx = 2'd0;
            @(negedge clk);
            cmd_valid = 1'b0; key_bus = '0;
            for (int n = 0; n < 12; n++) begin
                if (srch_valid) pulses++;
                @(negedge clk);
            end
            chk(pulses == 1, "R2", "result count", KW'(pulses), KW'(1));
            chk(sram_addr == AW'(9), "R2", "addr", KW'(sram_addr), KW'(9));
        end

        // R10 back-to-back: hit 9, miss, hit 0
        begin
            logic          rce [16];
            logic          rv  [16];
            logic          rf  [16];
            logic [AW-1:0] ra  [16];
            for (int n = 0; n < 16; n++) begin
                rce[n] = sram_ce_n; rv[n] = srch_valid; rf[n] = srch_found; ra[n] = sram_addr;
                cmd_valid = (n == 0 || n == 2 || n == 4);
                cmd_idx = 2'd0;
                key_bus = (n < 2) ? K2 : (n < 4) ? K4 : (n < 6) ? K6 : '0;
                @(negedge clk);
            end
            chk(!rce[5] && ra[5] == AW'(9), "R10", "first addr", KW'(ra[5]), KW'(9));
            chk(rce[7] && ra[7] == AW'(9), "R10", "miss holds addr", KW'(ra[7]), KW'(9));
            chk(!rce[9] && ra[9] == AW'(0), "R10", "third addr", KW'(ra[9]), KW'(0));
            chk(rce[6] && rce[8], "R10", "no extra strobes", KW'({rce[6], rce[8]}), KW'(2'b11));
            chk(rv[7] && rf[7], "R10", "first flags", KW'({rv[7], rf[7]}), KW'(2'b11));
            chk(rv[9] && !rf[9], "R10", "second flags", KW'({rv[9], rf[9]}), KW'(2'b10));
            chk(rv[11] && rf[11], "R10", "third flags", KW'({rv[11], rf[11]}), KW'(2'b11));
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule